// File: doc/BRIEF.md
# Register-Target Access Size Guard

This block sits between a simplified bus-target request port and a 32-bit control/status register file. Only accesses that enable every byte lane pass through to the register file. Any other access still completes, but in one of two ways. A narrow read returns the whole 32-bit word. A narrow write is dropped. In both cases a sticky slave-bus-error status is latched. The status is visible in a local status register. It drives an error interrupt when its enable bit is set, and only a hardware reset or a soft reset clears it.

Read data is captured into a single holding buffer. The master collects it with a take strobe. If the master has not collected the data after `DISCARD_CYCLES` clocks (32768 by default), the buffer is flushed, a one-cycle discard pulse is raised, and the target returns to idle. The internal interrupt request, combined with the masked bus error, reaches the host interrupt output only while the gate bit of the host command word is set.

The guard owns three local word registers, all at byte addresses; every other address goes to the register file:
- The mode register, at `0x1F0`. Bit 0 is a self-clearing soft reset.
- The error-enable register, at `0x1F4`. Bit 0 enables the error interrupt.
- The error-status register, at `0x1F8`. Bit 0 holds the sticky error and is read-only.

Top module: `csr_size_guard`

## Requirements
- R1: An accepted write with `req_be` = 4'b1111 to a non-local address asserts `rf_we` in the accepting cycle with `rf_addr`/`rf_wdata` taken from the request. An accepted full read returns the register word on `rd_data`.
- R2: An accepted read with any `req_be` other than 4'b1111 still returns the complete 32-bit word.
- R3: An accepted write with `req_be` other than 4'b1111 leaves `rf_we` low and changes no local register.
- R4: Any accepted access with `req_be` other than 4'b1111 sets error-status bit 0 (address 0x1F8). Full accesses never set it.
- R5: The error status clears only on `rst_n` or a soft reset. A full write of 1 to the status register leaves it set, and later accesses still complete under R1 to R3.
- R6: `err_irq_o` equals error status AND error-enable bit 0 (address 0x1F4, written only by full writes, cleared only by `rst_n`).
- R7: `host_irq_o` is (`int_irq_i` OR `err_irq_o`) AND `cmd_word_i[10]`. With bit 10 clear it stays low.
- R8: Captured read data is held on `rd_data` with `rd_valid` high until `rd_take`. Only one read is outstanding, and `req_ready` is low while one is.
- R9: If data stays uncollected for `DISCARD_CYCLES` cycles after capture, `rd_valid` falls and `discard_pulse` is high for exactly one cycle. A `rd_take` after that has no effect. Completion or a new capture restarts the count.
- R10: A full write with bit 0 set to the mode register (0x1F0), or `soft_rst_i`, clears the error status, the pending read and the discard timer, and keeps the error enable. The mode bit self-clears one cycle after it is written.
- R11: `req_ready` is low in every cycle in which a soft reset is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| soft_rst_i | input | 1 | External soft-reset request |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (9) | Byte address |
| req_be | input | LANES (4) | Byte-lane enables |
| req_wdata | input | DATA_W (32) | Write data |
| rd_valid | output | 1 | Read data held for the master |
| rd_data | output | DATA_W (32) | Held read data |
| rd_take | input | 1 | Master collects held data |
| discard_pulse | output | 1 | One-cycle flush indication |
| rf_rd | output | 1 | Register-file read strobe |
| rf_we | output | 1 | Register-file write strobe |
| rf_addr | output | ADDR_W (9) | Register-file address |
| rf_wdata | output | DATA_W (32) | Register-file write data |
| rf_rdata | input | DATA_W (32) | Register-file read data, same cycle |
| int_irq_i | input | 1 | Internal interrupt request |
| cmd_word_i | input | CMD_W (16) | Host command word; bit 10 gates the host interrupt |
| err_irq_o | output | 1 | Masked bus-error interrupt |
| host_irq_o | output | 1 | Gated interrupt to the host |

## Verification
The bench goes after two asymmetric narrow-access cases. A narrow read must still return every byte of the word, so a design that masks lanes returns partial data. A narrow write must leave both the register file and the local registers untouched, so a leaky design overwrites a word or the enable. It checks that a write-one to the status register does not clear the sticky error, and that only the two soft-reset paths clear it while the enable survives. It waits out the full 32768-cycle discard window, checking data still held one cycle before the flush, the flush on the boundary cycle, a single-cycle pulse, and an ignored late take; an off-by-one timer fails at the boundary.

// File: rtl/csr_guard_pkg.sv
package csr_guard_pkg;

   // Classification of one request by its byte-lane enables
   typedef enum logic [1:0] {
      ACC_IDLE = 2'd0,
      ACC_FULL = 2'd1,
      ACC_PART = 2'd2
   } acc_kind_e;

   // Local field positions inside the guard's own registers
   localparam int unsigned SRST_BIT = 0;
   localparam int unsigned ERR_BIT  = 0;

endpackage

// File: rtl/csr_size_check.sv
module csr_size_check
   import csr_guard_pkg::*;
#(
   parameter int unsigned LANES = 4
) (
   input  logic             valid,
   input  logic [LANES-1:0] be,
   output acc_kind_e        kind
);

   logic [LANES-1:0] lane_ok;

   // Per-lane enable chain: a full access needs every lane set
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      if (g == 0) begin : g_first
         assign lane_ok[g] = be[g];
      end else begin : g_next
         assign lane_ok[g] = lane_ok[g-1] & be[g];
      end
   end

   always_comb begin
      if (!valid)                 kind = ACC_IDLE;
      else if (lane_ok[LANES-1])  kind = ACC_FULL;
      else                        kind = ACC_PART;
   end

endmodule

// File: rtl/csr_read_hold.sv
module csr_read_hold #(
   parameter int unsigned DATA_W         = 32,
   parameter int unsigned DISCARD_CYCLES = 32768
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   input  logic              take,
   output logic              pending,
   output logic [DATA_W-1:0] data,
   output logic              flushed
);

   localparam int unsigned CNT_W = (DISCARD_CYCLES > 2) ? $clog2(DISCARD_CYCLES) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DISCARD_CYCLES - 1);

   logic [CNT_W-1:0] age;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending <= 1'b0;
         data    <= '0;
         age     <= '0;
         flushed <= 1'b0;
      end else if (clr) begin
         pending <= 1'b0;
         data    <= '0;
         age     <= '0;
         flushed <= 1'b0;
      end else begin
         flushed <= 1'b0;
         if (load) begin
            pending <= 1'b1;
            data    <= load_data;
            age     <= '0;
         end else if (pending) begin
            if (take) begin
               pending <= 1'b0;
               age     <= '0;
            end else if (age == LAST) begin
               pending <= 1'b0;
               data    <= '0;
               age     <= '0;
               flushed <= 1'b1;
            end else begin
               age <= age + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/csr_irq_gate.sv
module csr_irq_gate #(
   parameter int unsigned CMD_W    = 16,
   parameter int unsigned GATE_BIT = 10,
   parameter bit          OUT_REG  = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             err_sts,
   input  logic             err_en,
   input  logic             int_irq,
   input  logic [CMD_W-1:0] cmd_word,
   output logic             err_irq,
   output logic             host_irq
);

   logic host_raw;
   logic unused_cmd;

   assign err_irq    = err_sts & err_en;
   assign host_raw   = (int_irq | err_irq) & cmd_word[GATE_BIT];
   assign unused_cmd = ^cmd_word;

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) host_irq <= 1'b0;
         else        host_irq <= host_raw;
      end
   end else begin : g_comb
      assign host_irq = host_raw;
   end

endmodule

// File: rtl/csr_size_guard.sv
module csr_size_guard
   import csr_guard_pkg::*;
#(
   parameter int unsigned DATA_W         = 32,
   parameter int unsigned ADDR_W         = 9,
   parameter int unsigned LANES          = DATA_W / 8,
   parameter int unsigned DISCARD_CYCLES = 32768,
   parameter int unsigned CMD_W          = 16,
   parameter int unsigned GATE_BIT       = 10,
   parameter bit          OUT_REG        = 1'b0,
   parameter logic [ADDR_W-1:0] MODE_ADDR = 9'h1F0,
   parameter logic [ADDR_W-1:0] EN_ADDR   = 9'h1F4,
   parameter logic [ADDR_W-1:0] STS_ADDR  = 9'h1F8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst_i,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [LANES-1:0]  req_be,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   input  logic              rd_take,
   output logic              discard_pulse,
   output logic              rf_rd,
   output logic              rf_we,
   output logic [ADDR_W-1:0] rf_addr,
   output logic [DATA_W-1:0] rf_wdata,
   input  logic [DATA_W-1:0] rf_rdata,
   input  logic              int_irq_i,
   input  logic [CMD_W-1:0]  cmd_word_i,
   output logic              err_irq_o,
   output logic              host_irq_o
);

   // Elaboration-time parameter checks
   if (DATA_W % 8 != 0 || LANES != DATA_W / 8) begin : g_bad_width
      $error("csr_size_guard: DATA_W must be a whole number of byte lanes");
   end
   if (DISCARD_CYCLES < 2) begin : g_bad_discard
      $error("csr_size_guard: DISCARD_CYCLES must be at least 2");
   end
   if (GATE_BIT >= CMD_W) begin : g_bad_gate
      $error("csr_size_guard: GATE_BIT outside command word");
   end

   acc_kind_e         kind;
   logic              accept, full_acc, part_acc;
   logic              hit_mode, hit_en, hit_sts, is_local;
   logic              mode_srst, soft_active;
   logic              err_en, err_sts;
   logic [DATA_W-1:0] loc_rdata, cap_data;
   logic              cap_load;

   csr_size_check #(.LANES(LANES)) u_size (
      .valid (req_valid),
      .be    (req_be),
      .kind  (kind)
   );

   assign soft_active = mode_srst | soft_rst_i;
   assign req_ready   = !rd_valid && !soft_active;
   assign accept      = req_valid && req_ready;
   assign full_acc    = accept && (kind == ACC_FULL);
   assign part_acc    = accept && (kind == ACC_PART);

   assign hit_mode = (req_addr == MODE_ADDR);
   assign hit_en   = (req_addr == EN_ADDR);
   assign hit_sts  = (req_addr == STS_ADDR);
   assign is_local = hit_mode | hit_en | hit_sts;

   // Register-file port: full writes only, reads of any size
   assign rf_we    = full_acc && req_write && !is_local;
   assign rf_rd    = accept && !req_write && !is_local;
   assign rf_addr  = req_addr;
   assign rf_wdata = req_wdata;

   always_comb begin
      loc_rdata = '0;
      if (hit_mode)     loc_rdata[SRST_BIT] = mode_srst;
      else if (hit_en)  loc_rdata[ERR_BIT]  = err_en;
      else if (hit_sts) loc_rdata[ERR_BIT]  = err_sts;
   end

   assign cap_load = accept && !req_write;
   assign cap_data = is_local ? loc_rdata : rf_rdata;

   // Local registers: soft-reset bit, error enable, sticky error
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_srst <= 1'b0;
         err_en    <= 1'b0;
         err_sts   <= 1'b0;
      end else begin
         mode_srst <= full_acc && req_write && hit_mode && req_wdata[SRST_BIT];
         if (full_acc && req_write && hit_en)
            err_en <= req_wdata[ERR_BIT];
         if (soft_active)
            err_sts <= 1'b0;
         else if (part_acc)
            err_sts <= 1'b1;
      end
   end

   csr_read_hold #(
      .DATA_W         (DATA_W),
      .DISCARD_CYCLES (DISCARD_CYCLES)
   ) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (soft_active),
      .load      (cap_load),
      .load_data (cap_data),
      .take      (rd_take),
      .pending   (rd_valid),
      .data      (rd_data),
      .flushed   (discard_pulse)
   );

   csr_irq_gate #(
      .CMD_W    (CMD_W),
      .GATE_BIT (GATE_BIT),
      .OUT_REG  (OUT_REG)
   ) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .err_sts  (err_sts),
      .err_en   (err_en),
      .int_irq  (int_irq_i),
      .cmd_word (cmd_word_i),
      .err_irq  (err_irq_o),
      .host_irq (host_irq_o)
   );

endmodule

// File: rtl/csr_size_guard_chk.sv
module csr_size_guard_chk #(
   parameter int unsigned DATA_W         = 32,
   parameter int unsigned LANES          = 4,
   parameter int unsigned DISCARD_CYCLES = 32768,
   parameter int unsigned CMD_W          = 16,
   parameter int unsigned GATE_BIT       = 10,
   parameter bit          OUT_REG        = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              req_write,
   input logic [LANES-1:0]  req_be,
   input logic              rf_we,
   input logic              rd_valid,
   input logic [DATA_W-1:0] rd_data,
   input logic              rd_take,
   input logic              discard_pulse,
   input logic              err_sts,
   input logic              soft_active,
   input logic [CMD_W-1:0]  cmd_word_i,
   input logic              host_irq_o
);

   logic [31:0] held_cycles;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        held_cycles <= '0;
      else if (rd_valid) held_cycles <= held_cycles + 1;
      else               held_cycles <= '0;
   end

   // R3: a narrow write never reaches the register file
   p_part_wr_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_write && req_be != {LANES{1'b1}}) |-> !rf_we);

   // R4: a narrow access latches the error
   p_err_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_be != {LANES{1'b1}}) |=> err_sts);

   // R5: the error holds unless a soft reset is active
   p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (err_sts && !soft_active) |=> err_sts);

   // R8: held data is stable until taken or flushed
   p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !rd_take && !soft_active) |=> (!rd_valid || $stable(rd_data)));

   // R8: no new request while data is held
   p_one_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> !req_ready);

   // R9: the flush pulse lasts one cycle and leaves the buffer empty
   p_discard_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
      discard_pulse |=> !discard_pulse);
   p_discard_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
      discard_pulse |-> !rd_valid);

   // R9: data is never held longer than the discard window
   p_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> (held_cycles < DISCARD_CYCLES));

   // R11: no acceptance during a soft reset
   p_srst_block_r11: assert property (@(posedge clk) disable iff (!rst_n)
      soft_active |-> !req_ready);

   // R7: the gate bit low keeps the host interrupt low
   if (OUT_REG) begin : g_gate_reg
      p_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
         !cmd_word_i[GATE_BIT] |=> !host_irq_o);
   end else begin : g_gate_comb
      p_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
         !cmd_word_i[GATE_BIT] |-> !host_irq_o);
   end

endmodule

bind csr_size_guard csr_size_guard_chk #(
   .DATA_W         (DATA_W),
   .LANES          (LANES),
   .DISCARD_CYCLES (DISCARD_CYCLES),
   .CMD_W          (CMD_W),
   .GATE_BIT       (GATE_BIT),
   .OUT_REG        (OUT_REG)
) u_chk (.*);

// File: tb/sim_csr_size_guard.sv
`timescale 1ns/1ps
module sim_csr_size_guard;

   localparam int unsigned D = 32768;
   localparam logic [8:0] A_MODE = 9'h1F0;
   localparam logic [8:0] A_EN   = 9'h1F4;
   localparam logic [8:0] A_STS  = 9'h1F8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        soft_rst_i = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [8:0]  req_addr = '0;
   logic [3:0]  req_be = '0;
   logic [31:0] req_wdata = '0;
   logic        rd_valid;
   logic [31:0] rd_data;
   logic        rd_take = 1'b0;
   logic        discard_pulse;
   logic        rf_rd, rf_we;
   logic [8:0]  rf_addr;
   logic [31:0] rf_wdata, rf_rdata;
   logic        int_irq_i = 1'b0;
   logic [15:0] cmd_word_i = '0;
   logic        err_irq_o, host_irq_o;

   int total = 0;
   int bad = 0;
   logic [31:0] rf_mem [16];
   logic [31:0] exp_mem [16];
   logic        exp_err = 1'b0;

   always #2.5 clk = ~clk;

   csr_size_guard #(.DISCARD_CYCLES(D)) u0 (.*);

   // Register-file environment model
   always_ff @(posedge clk) if (rf_we) rf_mem[rf_addr[5:2]] <= rf_wdata;
   assign rf_rdata = rf_mem[rf_addr[5:2]];

   function automatic logic [31:0] seed_word(input int i);
      return 32'hA500_0000 ^ (32'h0101_0101 * i);
   endfunction

   function automatic logic [31:0] exp_read(input logic [8:0] a);
      return exp_mem[a[5:2]];
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Drive one request at a negedge; result visible at the next negedge
   task automatic access(input logic wr, input logic [8:0] a, input logic [3:0] be,
                         input logic [31:0] d);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_be = be; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
   endtask

   task automatic take();
      rd_take = 1'b1;
      @(negedge clk);
      rd_take = 1'b0;
   endtask

   task automatic read_word(input logic [8:0] a, input logic [3:0] be, output logic [31:0] d);
      access(1'b0, a, be, '0);
      d = rd_data;
      take();
   endtask

   initial begin
      logic [31:0] v;
      void'($urandom(32'd20240611));
      for (int i = 0; i < 16; i++) begin
         rf_mem[i] = seed_word(i);
         exp_mem[i] = seed_word(i);
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // Reset state
      chk("R8 ready after reset", {31'b0, req_ready}, 32'd1);
      chk("R8 no data after reset", {31'b0, rd_valid}, 32'd0);
      chk("R6 no err irq after reset", {31'b0, err_irq_o}, 32'd0);
      chk("R9 no discard after reset", {31'b0, discard_pulse}, 32'd0);

      // R1: full write strobes register file, full read returns it
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = 9'h00C; req_be = 4'hF;
      req_wdata = 32'hDEAD_BEEF;
      #1 chk("R1 full write strobe", {31'b0, rf_we}, 32'd1);
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
      exp_mem[3] = 32'hDEAD_BEEF;
      read_word(9'h00C, 4'hF, v);
      chk("R1 full read data", v, exp_read(9'h00C));
      chk("R1 rd_valid clears after take", {31'b0, rd_valid}, 32'd0);

      // R2: narrow read still returns whole word
      read_word(9'h010, 4'b0001, v);
      exp_err = 1'b1;
      chk("R2 narrow read full word", v, exp_read(9'h010));

      // R4: status bit 0 at 0x1F8 now set
      read_word(A_STS, 4'hF, v);
      chk("R4 error status after narrow read", v, {31'b0, exp_err});

      // R3: narrow write dropped, no strobe, no change
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = 9'h014; req_be = 4'b0011;
      req_wdata = 32'h1234_5678;
      #1 chk("R3 narrow write no strobe", {31'b0, rf_we}, 32'd0);
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
      read_word(9'h014, 4'hF, v);
      chk("R3 word unchanged", v, exp_read(9'h014));

      // R6: enable bit 0 at 0x1F4 masks the error interrupt
      chk("R6 masked while enable clear", {31'b0, err_irq_o}, 32'd0);
      access(1'b1, A_EN, 4'hF, 32'h1);
      chk("R6 irq with enable set", {31'b0, err_irq_o}, 32'd1);

      // R3: narrow write to local enable register ignored
      access(1'b1, A_EN, 4'b1110, 32'h0);
      read_word(A_EN, 4'hF, v);
      chk("R3 local enable kept", v, 32'd1);

      // R5: write-one to status ignored, accesses still work
      access(1'b1, A_STS, 4'hF, 32'h1);
      access(1'b1, A_STS, 4'hF, 32'h0);
      read_word(A_STS, 4'hF, v);
      chk("R5 status sticky after writes", v, 32'd1);
      access(1'b1, 9'h020, 4'hF, 32'h0BAD_F00D);
      exp_mem[8] = 32'h0BAD_F00D;
      read_word(9'h020, 4'hF, v);
      chk("R5 full access works while error latched", v, exp_read(9'h020));

      // R7: command bit 10 gates the host interrupt
      cmd_word_i = 16'hFBFF;
      #1 chk("R7 gate bit clear blocks", {31'b0, host_irq_o}, 32'd0);
      cmd_word_i = 16'h0400;
      #1 chk("R7 gate bit set passes error", {31'b0, host_irq_o}, 32'd1);
      access(1'b1, A_EN, 4'hF, 32'h0);
      chk("R7 no source no host irq", {31'b0, host_irq_o}, 32'd0);
      int_irq_i = 1'b1;
      #1 chk("R7 internal request passes", {31'b0, host_irq_o}, 32'd1);
      cmd_word_i = 16'h0000;
      #1 chk("R7 internal request gated", {31'b0, host_irq_o}, 32'd0);
      int_irq_i = 1'b0;
      access(1'b1, A_EN, 4'hF, 32'h1);

      // R10/R11: soft reset through mode register bit 0 at 0x1F0
      access(1'b1, A_MODE, 4'hF, 32'h1);
      chk("R11 not ready during soft reset", {31'b0, req_ready}, 32'd0);
      @(negedge clk);
      chk("R10 mode bit self-clears", {31'b0, req_ready}, 32'd1);
      exp_err = 1'b0;
      read_word(A_STS, 4'hF, v);
      chk("R10 error cleared by mode bit", v, 32'd0);
      read_word(A_EN, 4'hF, v);
      chk("R10 enable kept", v, 32'd1);
      read_word(A_MODE, 4'hF, v);
      chk("R10 mode bit reads zero", v, 32'd0);

      // R8: ready low while a read is held
      access(1'b0, 9'h004, 4'hF, '0);
      chk("R8 ready low while pending", {31'b0, req_ready}, 32'd0);
      repeat (3) @(negedge clk);
      chk("R8 data held", rd_data, exp_read(9'h004));

      // R10/R11: external soft reset drops the held read and clears error
      soft_rst_i = 1'b1;
      #1 chk("R11 external soft reset blocks", {31'b0, req_ready}, 32'd0);
      @(negedge clk);
      soft_rst_i = 1'b0;
      chk("R10 pending read dropped", {31'b0, rd_valid}, 32'd0);

      // R9: discard window
      access(1'b0, 9'h008, 4'hF, '0);
      repeat (D - 1) @(negedge clk);
      chk("R9 still held at window end", {31'b0, rd_valid}, 32'd1);
      @(negedge clk);
      chk("R9 flushed after window", {31'b0, rd_valid}, 32'd0);
      chk("R9 discard pulse", {31'b0, discard_pulse}, 32'd1);
      take();
      chk("R9 pulse one cycle", {31'b0, discard_pulse}, 32'd0);
      chk("R9 late take no effect", {31'b0, rd_valid}, 32'd0);
      chk("R9 ready after flush", {31'b0, req_ready}, 32'd1);

      // Random mix against the expected model
      for (int n = 0; n < 400; n++) begin
         logic [8:0] a;
         logic [3:0] be;
         logic       wr;
         logic [31:0] d;
         a  = {3'b0, 4'($urandom % 16), 2'b00};
         be = ($urandom % 3 == 0) ? 4'($urandom) : 4'hF;
         wr = 1'($urandom);
         d  = $urandom;
         if (be != 4'hF) exp_err = 1'b1;
         if (wr) begin
            access(1'b1, a, be, d);
            if (be == 4'hF) exp_mem[a[5:2]] = d;
         end else begin
            access(1'b0, a, be, '0);
            repeat ($urandom % 4) @(negedge clk);
            chk(be == 4'hF ? "R1 random read" : "R2 random narrow read", rd_data, exp_read(a));
            take();
         end
         if (n % 50 == 49) begin
            read_word(A_STS, 4'hF, v);
            chk("R4 random error status", v, {31'b0, exp_err});
         end
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule